// File: doc/BRIEF.md
# Remote Subblock Copy Buffer

Each cluster of an interleaved-cache machine owns one word-wide slice of every cache line. A load whose home slice belongs to another cluster must cross the memory bus. This buffer sits beside the local cache slice and keeps recent copies of remote subblocks, so that repeated remote accesses can be answered inside the cluster. A subblock is the pair of words that one home cluster owns in a line: word k and word k+4 of a 32-byte line for home cluster k.

The buffer is probed in the same cycle as the local slice. A probe compares every entry's line tag and home-cluster ID, selects the lower or upper stored word, and returns the word with a hit flag. Fills from the remote path load a tag, a subblock ID and both words, and they allocate entries in FIFO order. Local stores to a held address update the stored word in place. A flush input drops every entry at once, for use at the edges of memory-dependent regions.

Top module: `remote_subblock_buf`

## Requirements
- R1: An address splits as byte offset [1:0], home cluster ID (subblock ID) [3:2], word select [4] and line tag [31:5]. A probe hits only on a valid entry whose tag and subblock ID both match, and the byte offset is ignored.
- R2: A probe answers in the same cycle through combinational logic. While probe_valid_i is low, probe_hit_o is 0 and probe_data_o is 0, and every miss returns data 0.
- R3: On a hit, address bit 4 at 0 returns the lower stored word (fill_lo_i), and bit 4 at 1 returns the upper word (fill_hi_i).
- R4: A fill becomes visible from the next rising edge. A probe in the same cycle as the fill sees the contents from before the fill.
- R5: A fill whose tag and subblock ID are already held overwrites that entry in place and allocates no new entry. No two valid entries ever match one key.
- R6: There are 8 entries, replaced in FIFO order. The ninth distinct fill evicts the oldest allocation and keeps the other seven.
- R7: A store to a held address overwrites the word picked by bit 4 and leaves the other word unchanged. A store to an address that is not held changes nothing and allocates nothing.
- R8: When a store and a fill target the same subblock in one cycle, the stored word comes from the store and the other word comes from the fill.
- R9: Flush invalidates all entries in one cycle, and a fill or store in the flush cycle is dropped. Allocation restarts at the first entry.
- R10: Asynchronous active-low reset leaves every entry invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| probe_valid_i | input | 1 | Probe request |
| probe_addr_i | input | 32 | Probe byte address |
| probe_hit_o | output | 1 | Probe hit, same cycle |
| probe_data_o | output | 32 | Selected word, 0 on miss |
| fill_valid_i | input | 1 | Fill request |
| fill_tag_i | input | 27 | Line tag of the fill |
| fill_sub_i | input | 2 | Home cluster ID of the fill |
| fill_lo_i | input | 32 | Lower word (word k) |
| fill_hi_i | input | 32 | Upper word (word k+4) |
| store_valid_i | input | 1 | Local store request |
| store_addr_i | input | 32 | Store byte address |
| store_data_i | input | 32 | Store word |
| flush_i | input | 1 | Invalidate all entries |

## Verification
A fill and a store can land on the same subblock in one edge, and a flush can coincide with either. The bench drives a new fill together with a store to the upper word of that subblock. It then probes both halves and expects the fill's lower word and the store's upper word. It also drives a flush together with a fill and a store, and expects misses afterwards. A probe issued in the cycle of a fill is judged against the contents from before the fill.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int unsigned RSB_ADDR_W     = 32;
  localparam int unsigned RSB_DATA_W     = 32;
  localparam int unsigned RSB_ENTRIES    = 8;
  localparam int unsigned RSB_CLUSTERS   = 4;
  localparam int unsigned RSB_WORD_BYTES = 4;
endpackage

// File: rtl/rsb_match.sv
module rsb_match #(
  parameter int unsigned N     = 8,
  parameter int unsigned TAG_W = 27,
  parameter int unsigned CID_W = 2
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][TAG_W-1:0] tag_i,
  input  logic [N-1:0][CID_W-1:0] sub_i,
  input  logic [TAG_W-1:0]        q_tag_i,
  input  logic [CID_W-1:0]        q_sub_i,
  output logic [N-1:0]            hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_o[i] = valid_i[i] && (tag_i[i] == q_tag_i) && (sub_i[i] == q_sub_i);
  end
endmodule

// File: rtl/rsb_wsel.sv
module rsb_wsel #(
  parameter int unsigned N      = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic [N-1:0]             hit_i,
  input  logic [N-1:0][DATA_W-1:0] lo_i,
  input  logic [N-1:0][DATA_W-1:0] hi_i,
  input  logic                     sel_hi_i,
  output logic [DATA_W-1:0]        data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_i[i]) data_o = data_o | (sel_hi_i ? hi_i[i] : lo_i[i]);
    end
  end
endmodule

// File: rtl/rsb_alloc.sv
module rsb_alloc #(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         adv_i,
  output logic [N-1:0] victim_oh_o
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (flush_i)  ptr_q <= '0;
    else if (adv_i)    ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
  end

  assign victim_oh_o = {{(N-1){1'b0}}, 1'b1} << ptr_q;

  AST_FLUSH_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> victim_oh_o[0]); // R9
endmodule

// File: rtl/remote_subblock_buf.sv
module remote_subblock_buf
  import rsb_pkg::*;
#(
  parameter int unsigned ADDR_W     = RSB_ADDR_W,
  parameter int unsigned DATA_W     = RSB_DATA_W,
  parameter int unsigned N_ENTRIES  = RSB_ENTRIES,
  parameter int unsigned N_CLUSTERS = RSB_CLUSTERS,
  parameter int unsigned WORD_BYTES = RSB_WORD_BYTES,
  localparam int unsigned OFF_W   = $clog2(WORD_BYTES),
  localparam int unsigned CID_W   = $clog2(N_CLUSTERS),
  localparam int unsigned SEL_BIT = OFF_W + CID_W,
  localparam int unsigned TAG_LSB = SEL_BIT + 1,
  localparam int unsigned TAG_W   = ADDR_W - TAG_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              probe_valid_i,
  input  logic [ADDR_W-1:0] probe_addr_i,
  output logic              probe_hit_o,
  output logic [DATA_W-1:0] probe_data_o,
  input  logic              fill_valid_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [CID_W-1:0]  fill_sub_i,
  input  logic [DATA_W-1:0] fill_lo_i,
  input  logic [DATA_W-1:0] fill_hi_i,
  input  logic              store_valid_i,
  input  logic [ADDR_W-1:0] store_addr_i,
  input  logic [DATA_W-1:0] store_data_i,
  input  logic              flush_i
);
  localparam int unsigned N = N_ENTRIES;

  logic [N-1:0]             valid_q;
  logic [N-1:0][TAG_W-1:0]  tag_q;
  logic [N-1:0][CID_W-1:0]  sub_q;
  logic [N-1:0][DATA_W-1:0] lo_q, hi_q;

  logic [TAG_W-1:0] p_tag, s_tag;
  logic [CID_W-1:0] p_sub, s_sub;
  logic             p_hi, s_hi;
  logic [N-1:0]     p_hit, f_hit, s_hit, victim_oh, fill_wr, st_wr;
  logic [DATA_W-1:0] sel_data;
  logic             fill_go, fill_new, st_eq_fill;
  logic             unused_off;

  assign p_tag = probe_addr_i[ADDR_W-1:TAG_LSB];
  assign p_sub = probe_addr_i[SEL_BIT-1:OFF_W];
  assign p_hi  = probe_addr_i[SEL_BIT];
  assign s_tag = store_addr_i[ADDR_W-1:TAG_LSB];
  assign s_sub = store_addr_i[SEL_BIT-1:OFF_W];
  assign s_hi  = store_addr_i[SEL_BIT];
  assign unused_off = ^{probe_addr_i[OFF_W-1:0], store_addr_i[OFF_W-1:0]};

  rsb_match #(.N(N), .TAG_W(TAG_W), .CID_W(CID_W)) u_probe_match (
    .valid_i(valid_q), .tag_i(tag_q), .sub_i(sub_q),
    .q_tag_i(p_tag), .q_sub_i(p_sub), .hit_o(p_hit));

  rsb_match #(.N(N), .TAG_W(TAG_W), .CID_W(CID_W)) u_fill_match (
    .valid_i(valid_q), .tag_i(tag_q), .sub_i(sub_q),
    .q_tag_i(fill_tag_i), .q_sub_i(fill_sub_i), .hit_o(f_hit));

  rsb_match #(.N(N), .TAG_W(TAG_W), .CID_W(CID_W)) u_store_match (
    .valid_i(valid_q), .tag_i(tag_q), .sub_i(sub_q),
    .q_tag_i(s_tag), .q_sub_i(s_sub), .hit_o(s_hit));

  rsb_wsel #(.N(N), .DATA_W(DATA_W)) u_wsel (
    .hit_i(p_hit), .lo_i(lo_q), .hi_i(hi_q), .sel_hi_i(p_hi), .data_o(sel_data));

  assign fill_go  = fill_valid_i && !flush_i;
  assign fill_new = fill_go && !(|f_hit);

  rsb_alloc #(.N(N)) u_alloc (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .adv_i(fill_new), .victim_oh_o(victim_oh));

  // refill goes in place, otherwise into the FIFO victim
  assign fill_wr    = fill_go ? ((|f_hit) ? f_hit : victim_oh) : '0;
  assign st_eq_fill = (fill_tag_i == s_tag) && (fill_sub_i == s_sub);

  // store follows the key that the entry holds after this edge
  for (genvar i = 0; i < N; i++) begin : g_st
    assign st_wr[i] = store_valid_i && !flush_i && (fill_wr[i] ? st_eq_fill : s_hit[i]);
  end

  for (genvar i = 0; i < N; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
        sub_q[i]   <= '0;
        lo_q[i]    <= '0;
        hi_q[i]    <= '0;
      end else if (flush_i) begin
        valid_q[i] <= 1'b0;
      end else begin
        if (fill_wr[i]) begin
          valid_q[i] <= 1'b1;
          tag_q[i]   <= fill_tag_i;
          sub_q[i]   <= fill_sub_i;
          lo_q[i]    <= fill_lo_i;
          hi_q[i]    <= fill_hi_i;
        end
        if (st_wr[i]) begin
          if (s_hi) hi_q[i] <= store_data_i;
          else      lo_q[i] <= store_data_i;
        end
      end
    end
  end

  assign probe_hit_o  = probe_valid_i && (|p_hit);
  assign probe_data_o = probe_valid_i ? sel_data : '0;

  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !probe_hit_o |-> (probe_data_o == '0)); // R2

  AST_UNIQUE_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(p_hit)); // R5

  AST_FILL_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i && !flush_i |=>
      (!probe_valid_i || p_tag != $past(fill_tag_i) || p_sub != $past(fill_sub_i) || probe_hit_o)); // R4

  AST_STORE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|st_wr) |=>
      (!probe_valid_i || probe_addr_i[ADDR_W-1:OFF_W] != $past(store_addr_i[ADDR_W-1:OFF_W]) ||
       probe_data_o == $past(store_data_i))); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !probe_hit_o); // R9
endmodule

// File: tb/remote_subblock_buf_bench.sv
`timescale 1ns/1ps
module remote_subblock_buf_bench;
  localparam logic [1:0] OP_PROBE = 2'd0, OP_FILL = 2'd1, OP_STORE = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [31:0] d0;
    logic [31:0] d1;
    logic        eh;
    logic [31:0] ed;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{OP_PROBE, 32'h0000_1004, 32'h0, 32'h0, 1'b0, 32'h0},                  // R1 empty
    '{OP_FILL,  32'h0000_1004, 32'hAAAA_0001, 32'hBBBB_0001, 1'b0, 32'h0},
    '{OP_PROBE, 32'h0000_1004, 32'h0, 32'h0, 1'b1, 32'hAAAA_0001},          // R3 low word
    '{OP_PROBE, 32'h0000_1014, 32'h0, 32'h0, 1'b1, 32'hBBBB_0001},          // R3 high word
    '{OP_PROBE, 32'h0000_1008, 32'h0, 32'h0, 1'b0, 32'h0},                  // R1 other cluster
    '{OP_PROBE, 32'h0000_2004, 32'h0, 32'h0, 1'b0, 32'h0},                  // R1 other tag
    '{OP_PROBE, 32'h0000_1007, 32'h0, 32'h0, 1'b1, 32'hAAAA_0001},          // R1 byte offset
    '{OP_STORE, 32'h0000_1014, 32'hCCCC_0001, 32'h0, 1'b0, 32'h0},
    '{OP_PROBE, 32'h0000_1014, 32'h0, 32'h0, 1'b1, 32'hCCCC_0001},          // R7 updated
    '{OP_PROBE, 32'h0000_1004, 32'h0, 32'h0, 1'b1, 32'hAAAA_0001},          // R7 other word kept
    '{OP_STORE, 32'h0000_3008, 32'hDEAD_0001, 32'h0, 1'b0, 32'h0},
    '{OP_PROBE, 32'h0000_3008, 32'h0, 32'h0, 1'b0, 32'h0},                  // R7 no allocation
    '{OP_FILL,  32'h0000_1004, 32'h1111_0000, 32'h2222_0000, 1'b0, 32'h0},
    '{OP_PROBE, 32'h0000_1014, 32'h0, 32'h0, 1'b1, 32'h2222_0000}           // R5 refill
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic probe_valid_i = 0, fill_valid_i = 0, store_valid_i = 0, flush_i = 0;
  logic [31:0] probe_addr_i = '0, store_addr_i = '0, store_data_i = '0;
  logic [26:0] fill_tag_i = '0;
  logic [1:0]  fill_sub_i = '0;
  logic [31:0] fill_lo_i = '0, fill_hi_i = '0;
  logic        probe_hit_o;
  logic [31:0] probe_data_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  remote_subblock_buf u_remote_subblock_buf (
    .clk_i(clk), .rst_ni(rst_ni),
    .probe_valid_i(probe_valid_i), .probe_addr_i(probe_addr_i),
    .probe_hit_o(probe_hit_o), .probe_data_o(probe_data_o),
    .fill_valid_i(fill_valid_i), .fill_tag_i(fill_tag_i), .fill_sub_i(fill_sub_i),
    .fill_lo_i(fill_lo_i), .fill_hi_i(fill_hi_i),
    .store_valid_i(store_valid_i), .store_addr_i(store_addr_i),
    .store_data_i(store_data_i), .flush_i(flush_i));

  task automatic check(string req, logic eh, logic [31:0] ed);
    n_chk++;
    if (probe_hit_o !== eh || probe_data_o !== ed) begin
      n_fail++;
      $display("FAIL %s addr=%h hit=%b data=%h expected hit=%b data=%h",
               req, probe_addr_i, probe_hit_o, probe_data_o, eh, ed);
    end
  endtask

  task automatic set_fill(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
    fill_valid_i = 1; fill_tag_i = a[31:5]; fill_sub_i = a[3:2];
    fill_lo_i = lo; fill_hi_i = hi;
  endtask

  task automatic set_store(logic [31:0] a, logic [31:0] d);
    store_valid_i = 1; store_addr_i = a; store_data_i = d;
  endtask

  task automatic commit();
    @(posedge clk); #1;
    fill_valid_i = 0; store_valid_i = 0; flush_i = 0;
  endtask

  task automatic probe(string req, logic [31:0] a, logic eh, logic [31:0] ed);
    @(negedge clk);
    probe_valid_i = 1; probe_addr_i = a;
    #1 check(req, eh, ed);
    probe_valid_i = 0;
  endtask

  function automatic logic [31:0] k_addr(int k);
    return 32'h0001_0000 + 32'(k) * 32'h20 + 32'h4;
  endfunction

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    probe("R10 reset empty", 32'h0000_1004, 1'b0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      case (VEC[i].op)
        OP_FILL:  begin set_fill(VEC[i].addr, VEC[i].d0, VEC[i].d1); commit(); end
        OP_STORE: begin set_store(VEC[i].addr, VEC[i].d0); commit(); end
        default:  probe($sformatf("vector %0d", i), VEC[i].addr, VEC[i].eh, VEC[i].ed);
      endcase
    end

    // R2: probe_valid low on a held address
    @(negedge clk);
    probe_valid_i = 0; probe_addr_i = 32'h0000_1004;
    #1 check("R2 no probe", 1'b0, 32'h0);

    // R6 / R5: flush, refill once, fill up, then evict oldest
    @(negedge clk); flush_i = 1; commit();
    @(negedge clk); set_fill(k_addr(0), 32'h100, 32'h200); commit();
    @(negedge clk); set_fill(k_addr(0), 32'h150, 32'h250); commit();
    for (int k = 1; k < 8; k++) begin
      @(negedge clk); set_fill(k_addr(k), 32'h100 + 32'(k), 32'h200 + 32'(k)); commit();
    end
    probe("R5 refill kept", k_addr(0), 1'b1, 32'h150);
    probe("R6 entry 7 held", k_addr(7), 1'b1, 32'h107);
    @(negedge clk); set_fill(k_addr(8), 32'h108, 32'h208); commit();
    probe("R6 oldest evicted", k_addr(0), 1'b0, 32'h0);
    probe("R6 second kept", k_addr(1), 1'b1, 32'h101);
    probe("R6 new entry", k_addr(8) | 32'h10, 1'b1, 32'h208);

    // R4: probe in the fill cycle sees old contents
    @(negedge clk);
    set_fill(32'h0000_5004, 32'h51, 32'h52);
    probe_valid_i = 1; probe_addr_i = 32'h0000_5004;
    #1 check("R4 same cycle", 1'b0, 32'h0);
    @(posedge clk); #1;
    fill_valid_i = 0;
    check("R4 next cycle", 1'b1, 32'h51);
    probe_valid_i = 0;

    // R8: fill and store on the same subblock
    @(negedge clk);
    set_fill(32'h0000_6008, 32'h61, 32'h62);
    set_store(32'h0000_6018, 32'h69);
    commit();
    probe("R8 low from fill", 32'h0000_6008, 1'b1, 32'h61);
    probe("R8 high from store", 32'h0000_6018, 1'b1, 32'h69);

    // R9: flush beats a fill and a store in the same cycle
    @(negedge clk);
    flush_i = 1;
    set_fill(32'h0000_7004, 32'h71, 32'h72);
    set_store(32'h0000_6008, 32'h6F);
    commit();
    probe("R9 flushed", 32'h0000_6008, 1'b0, 32'h0);
    probe("R9 fill dropped", 32'h0000_7004, 1'b0, 32'h0);
    @(negedge clk); set_fill(32'h0000_7004, 32'h71, 32'h72); commit();
    probe("R9 refill after flush", 32'h0000_7014, 1'b1, 32'h72);

    // R10: asynchronous reset mid-run
    @(negedge clk); rst_ni = 0;
    #2 rst_ni = 1;
    probe("R10 reset clears", 32'h0000_7004, 1'b0, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule